// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Aligner and Corrector

This block is the digital back end of a four-stage pipelined 12-bit converter. Each of the four sub-converter stages delivers a 4-bit code for every sample. Stage k of a sample arrives half a sample period after stage k-1 of that same sample. The block keeps the early codes in a short clocked delay line until all four codes of one sample are together. It then merges them by overlap-add correction. Neighbouring codes overlap by one bit, because the residue gain between stages is 8.

The block runs on a clock at twice the sample rate. The input `half_ph` tells the two halves of each sample period apart. A clock edge sampled with `half_ph` high ends a sample period and is the sample clock edge. The corrected 12-bit word is offset binary and is registered on sample clock edges. It appears a fixed three sample clocks after the sample edge that takes the sample in, and then one word follows per sample clock with no gaps.

Top module: `pipe_adc_aligner`

## Requirements
- R1: A synchronous active-high `rst` clears the delay line, the output word and the valid chain, so that `word_o` reads 0 and `word_vld` reads 0 while reset is held.
- R2: Stage 1 and stage 3 codes are captured only on edges with `half_ph` low, and stage 2 and stage 4 codes only on edges with `half_ph` high. Values present on a stage port during the other half-period have no effect on any output word.
- R3: For aligned codes B1..B4 (stage 1 first), the word is B1·512 + B2·64 + B3·8 + B4 − 292. The constant 292 is the overlap offset: half a step (4) at each of the weights 64, 8 and 1.
- R4: A corrected sum above 4095 is clamped to 4095 (all ones, positive full scale).
- R5: A corrected sum below 0 is clamped to 0 (all zeros, negative full scale).
- R6: Sample N is the sample whose stage 1 code is captured in sample period P and whose stage 3 and stage 4 codes arrive in period P+1. Its word is driven on `word_o` by the third sample clock edge after the one that ends period P. `word_o` changes only on sample clock edges, so it holds steady through the following low half-period.
- R7: Each successive sample's word appears on the next sample clock edge, with no gaps and no repeats.
- R8: After reset, `word_vld` rises on the sample clock edge that delivers the first sample's word, three sample edges after the first full sample period. It then stays high until the next reset.
- R9: Mid-scale stage codes 4, 4, 4, 4 produce 2048 (1000_0000_0000), the first code above the centre of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| half_ph | input | 1 | Half-period flag: 0 for stages 1/3, 1 for stages 2/4 and the sample clock edge |
| code_s1 | input | CODE_W | Stage 1 (most significant) code |
| code_s2 | input | CODE_W | Stage 2 code |
| code_s3 | input | CODE_W | Stage 3 code |
| code_s4 | input | CODE_W | Stage 4 (flash only) code |
| word_o | output | OUT_W | Corrected offset-binary word |
| word_vld | output | 1 | High once `word_o` carries a real sample |

## Verification
A sample's stage 1 code is captured in period P, and its word becomes visible after the sample edge ending period P+3. The path is the hold register on the low half, the alignment register at the end of P+1, the correction register at the end of P+2 and the output register at the end of P+3. The bench therefore compares each word at the falling edge that follows the fourth sample edge after the sample's first code. It compares the word again one half-period later to confirm it held. The valid flag is expected low on the first three sample edges after reset and high from the fourth on. Codes driven on a stage port during its idle half-period are random, so any leak into a word shows up as a mismatch.

// File: rtl/pipe_adc_pkg.sv
package pipe_adc_pkg;

   localparam int NSTG = 4;

   // overlap offset: half a step on every stage after the first
   function automatic int overlap_offset(input int code_w);
      int acc;
      acc = 0;
      for (int i = 0; i < NSTG - 1; i++)
         acc = (acc << (code_w - 1)) + (1 << (code_w - 2));
      return acc;
   endfunction

endpackage

// File: rtl/pipe_adc_skew_line.sv
module pipe_adc_skew_line #(
   parameter int CODE_W = 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           half_ph,
   input  logic [CODE_W-1:0]              code_s1,
   input  logic [CODE_W-1:0]              code_s2,
   input  logic [CODE_W-1:0]              code_s3,
   input  logic [CODE_W-1:0]              code_s4,
   output logic [pipe_adc_pkg::NSTG*CODE_W-1:0] al_codes,
   output logic                           al_vld
);
   logic [CODE_W-1:0] hold1, hold3, lag1, lag2;
   logic              hold_seen, lag_vld;

   // low half-period: stages 1 and 3 are captured
   always_ff @(posedge clk) begin
      if (rst) begin
         hold1     <= '0;
         hold3     <= '0;
         hold_seen <= 1'b0;
      end else if (!half_ph) begin
         hold1     <= code_s1;
         hold3     <= code_s3;
         hold_seen <= 1'b1;
      end
   end

   // sample edge: stages 2 and 4 are captured and one sample is aligned
   always_ff @(posedge clk) begin
      if (rst) begin
         lag1     <= '0;
         lag2     <= '0;
         lag_vld  <= 1'b0;
         al_codes <= '0;
         al_vld   <= 1'b0;
      end else if (half_ph) begin
         lag1     <= hold1;
         lag2     <= code_s2;
         lag_vld  <= hold_seen;
         al_codes <= {lag1, lag2, hold3, code_s4};
         al_vld   <= lag_vld;
      end
   end
endmodule

// File: rtl/pipe_adc_merge.sv
module pipe_adc_merge #(
   parameter int CODE_W = 4,
   parameter int OUT_W  = 12,
   parameter int OFFSET = 292
) (
   input  logic [pipe_adc_pkg::NSTG*CODE_W-1:0] al_codes,
   output logic [OUT_W-1:0]                     word
);
   localparam int NSTG  = pipe_adc_pkg::NSTG;
   localparam int STEP  = CODE_W - 1;
   localparam int SUM_W = OUT_W + 2;
   localparam logic [SUM_W-1:0] OFF_V = SUM_W'(OFFSET);
   localparam logic [SUM_W-1:0] MAX_V = SUM_W'((1 << OUT_W) - 1);

   logic [SUM_W-1:0] term [NSTG];
   logic [SUM_W-1:0] raw, diff;

   // stage gi = 0 is stage 1, at the top of the packed vector
   for (genvar gi = 0; gi < NSTG; gi++) begin : g_term
      assign term[gi] = {{(SUM_W-CODE_W){1'b0}}, al_codes[(NSTG-1-gi)*CODE_W +: CODE_W]}
                        << (STEP * (NSTG - 1 - gi));
   end

   always_comb begin
      raw = '0;
      for (int i = 0; i < NSTG; i++)
         raw = raw + term[i];
      diff = raw - OFF_V;
      if (raw < OFF_V)
         word = '0;
      else if (diff > MAX_V)
         word = MAX_V[OUT_W-1:0];
      else
         word = diff[OUT_W-1:0];
   end
endmodule

// File: rtl/pipe_adc_aligner.sv
module pipe_adc_aligner #(
   parameter int CODE_W = 4,
   parameter int OUT_W  = 12,
   parameter int OFFSET = pipe_adc_pkg::overlap_offset(CODE_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              half_ph,
   input  logic [CODE_W-1:0] code_s1,
   input  logic [CODE_W-1:0] code_s2,
   input  logic [CODE_W-1:0] code_s3,
   input  logic [CODE_W-1:0] code_s4,
   output logic [OUT_W-1:0]  word_o,
   output logic              word_vld
);
   localparam int NSTG = pipe_adc_pkg::NSTG;

   if (CODE_W < 2) begin : g_bad_code
      $error("CODE_W must be at least 2");
   end
   if (OUT_W != NSTG * (CODE_W - 1)) begin : g_bad_out
      $error("OUT_W must equal NSTG*(CODE_W-1)");
   end
   if (OFFSET < 0 || OFFSET >= (1 << OUT_W)) begin : g_bad_off
      $error("OFFSET out of range");
   end

   logic [NSTG*CODE_W-1:0] al_codes;
   logic                   al_vld;
   logic [OUT_W-1:0]       corr_word, mid_q;
   logic                   mid_vld;

   pipe_adc_skew_line #(.CODE_W(CODE_W)) u_skew (
      .clk      (clk),
      .rst      (rst),
      .half_ph  (half_ph),
      .code_s1  (code_s1),
      .code_s2  (code_s2),
      .code_s3  (code_s3),
      .code_s4  (code_s4),
      .al_codes (al_codes),
      .al_vld   (al_vld)
   );

   pipe_adc_merge #(.CODE_W(CODE_W), .OUT_W(OUT_W), .OFFSET(OFFSET)) u_merge (
      .al_codes (al_codes),
      .word     (corr_word)
   );

   // correction register, then output register, both on sample edges
   always_ff @(posedge clk) begin
      if (rst) begin
         mid_q    <= '0;
         mid_vld  <= 1'b0;
         word_o   <= '0;
         word_vld <= 1'b0;
      end else if (half_ph) begin
         mid_q    <= corr_word;
         mid_vld  <= al_vld;
         word_o   <= mid_q;
         word_vld <= mid_vld;
      end
   end
endmodule

// File: rtl/pipe_adc_aligner_chk.sv
module pipe_adc_aligner_chk #(
   parameter int CODE_W = 4,
   parameter int OUT_W  = 12,
   parameter int OFFSET = 292
) (
   input logic                                  clk,
   input logic                                  rst,
   input logic                                  half_ph,
   input logic [pipe_adc_pkg::NSTG*CODE_W-1:0]  al_codes,
   input logic                                  al_vld,
   input logic [OUT_W-1:0]                      word_o,
   input logic                                  word_vld
);
   localparam int STEP  = CODE_W - 1;
   localparam int MAXC  = (1 << CODE_W) - 1;
   localparam int SH1   = 3 * STEP;
   localparam int HI_T  = ((1 << OUT_W) + OFFSET + (1 << SH1) - 1) >> SH1;
   localparam int LO_R  = OFFSET - 1 - MAXC * (1 << STEP) - MAXC;
   localparam int LO_T  = (LO_R < 0) ? -1 : (LO_R >> (2 * STEP));
   localparam logic [OUT_W-1:0] MAX_W = '1;

   logic [CODE_W-1:0] a1, a2;
   assign a1 = al_codes[3*CODE_W +: CODE_W];
   assign a2 = al_codes[2*CODE_W +: CODE_W];

   // R6: the word only moves on sample edges
   a_r6_hold_half: assert property (@(posedge clk) disable iff (rst)
      $past(!half_ph) |-> $stable(word_o));

   // R8: valid rises on a sample edge and then stays
   a_r8_vld_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(word_vld) |-> $past(half_ph));
   a_r8_vld_keep: assert property (@(posedge clk) disable iff (rst)
      word_vld |=> word_vld);

   // R4: a large stage 1 code forces positive full scale
   a_r4_sat_high: assert property (@(posedge clk) disable iff (rst)
      (half_ph && al_vld && int'(a1) >= HI_T) |-> ##3 (word_o == MAX_W));

   // R5: a zero stage 1 code with a small stage 2 code forces zero
   a_r5_sat_low: assert property (@(posedge clk) disable iff (rst)
      (half_ph && al_vld && a1 == '0 && int'(a2) <= LO_T) |-> ##3 (word_o == '0));
endmodule

bind pipe_adc_aligner pipe_adc_aligner_chk #(
   .CODE_W (CODE_W),
   .OUT_W  (OUT_W),
   .OFFSET (OFFSET)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .half_ph  (half_ph),
   .al_codes (al_codes),
   .al_vld   (al_vld),
   .word_o   (word_o),
   .word_vld (word_vld)
);

// File: tb/pipe_adc_aligner_test.sv
module pipe_adc_aligner_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        half_ph = 1'b0;
   logic [3:0]  code_s1 = '0, code_s2 = '0, code_s3 = '0, code_s4 = '0;
   logic [11:0] word_o;
   logic        word_vld;

   int n_cmp = 0;
   int n_bad = 0;

   logic [15:0] strm  [256];
   int          exp_a [256];

   // {B1,B2,B3,B4, expected word}
   localparam logic [27:0] VEC [12] = '{
      {4'd4,  4'd4,  4'd4,  4'd4,  12'h800},  // R9 mid-scale
      {4'd15, 4'd15, 4'd15, 4'd15, 12'hFFF},  // R4
      {4'd0,  4'd0,  4'd0,  4'd0,  12'h000},  // R5
      {4'd7,  4'd11, 4'd11, 4'd11, 12'hFFF},  // exactly 4095
      {4'd0,  4'd4,  4'd4,  4'd5,  12'h001},  // just above zero
      {4'd0,  4'd4,  4'd4,  4'd3,  12'h000},  // -1 clamps, R5
      {4'd8,  4'd4,  4'd4,  4'd3,  12'hFFF},  // exactly 4095
      {4'd3,  4'd12, 4'd0,  4'd9,  12'h7E5},
      {4'd5,  4'd0,  4'd15, 4'd0,  12'h954},
      {4'd1,  4'd8,  4'd8,  4'd8,  12'h324},
      {4'd6,  4'd2,  4'd7,  4'd13, 12'hBA1},
      {4'd8,  4'd4,  4'd4,  4'd4,  12'hFFF}   // 4096 clamps, R4
   };

   pipe_adc_aligner uut (
      .clk      (clk),
      .rst      (rst),
      .half_ph  (half_ph),
      .code_s1  (code_s1),
      .code_s2  (code_s2),
      .code_s3  (code_s3),
      .code_s4  (code_s4),
      .word_o   (word_o),
      .word_vld (word_vld)
   );

   always #10 clk = ~clk;

   function automatic int ref_word(input logic [15:0] v);
      int r;
      r = int'(v[15:12]) * 512 + int'(v[11:8]) * 64 + int'(v[7:4]) * 8 + int'(v[3:0]) - 292;
      if (r < 0) r = 0;
      if (r > 4095) r = 4095;
      return r;
   endfunction

   task automatic chk(input string tag, input int act, input int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      half_ph = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 word after reset", int'(word_o), 0);
      chk("R1 valid after reset", int'(word_vld), 0);
      rst = 1'b0;
   endtask

   // entered at a falling edge; one sample per two clocks
   task automatic run_stream(input int n);
      for (int p = 0; p <= n + 4; p++) begin
         if (p >= 1 && p < 4)
            chk("R8 valid low before first word", int'(word_vld), 0);
         if (p >= 4 && p - 4 < n) begin
            chk("R3 R2 R7 word", int'(word_o), exp_a[p-4]);
            chk("R8 valid high", int'(word_vld), 1);
         end
         half_ph = 1'b0;
         code_s1 = (p < n) ? strm[p][15:12] : 4'd4;
         code_s3 = (p >= 1 && p - 1 < n) ? strm[p-1][7:4] : 4'd4;
         code_s2 = 4'($urandom);
         code_s4 = 4'($urandom);
         @(negedge clk);
         if (p >= 4 && p - 4 < n)
            chk("R6 word held over low half", int'(word_o), exp_a[p-4]);
         half_ph = 1'b1;
         code_s2 = (p < n) ? strm[p][11:8] : 4'd4;
         code_s4 = (p >= 1 && p - 1 < n) ? strm[p-1][3:0] : 4'd4;
         code_s1 = 4'($urandom);
         code_s3 = 4'($urandom);
         @(negedge clk);
      end
   endtask

   initial begin
      #(20 * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      for (int i = 0; i < 12; i++) begin
         strm[i]  = VEC[i][27:12];
         exp_a[i] = int'(VEC[i][11:0]);
      end
      run_stream(12);

      // flush leaves mid-scale on the output; reset must clear it (R1)
      chk("R9 flush word mid-scale", int'(word_o), 2048);
      do_reset();
      for (int i = 0; i < 200; i++) begin
         strm[i]  = 16'($urandom);
         exp_a[i] = ref_word(strm[i]);
      end
      run_stream(200);
      do_reset();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule